// File: doc/BRIEF.md
# DMA Transfer Request Sequencer

This block sits inside a compute component and moves data between the component's on-chip buffers and external DRAM, although it never addresses the DRAM itself. Its only master port reaches two small register targets: a hardware test-and-set lock and the control registers of a shared DMA engine. For each request from the compute logic, it first wins the lock. It then loads the engine with the source address, destination address and byte count, and sets it running. It waits for the engine's completion interrupt, clears that interrupt, frees the lock, and signals completion.

The compute side supplies four values: the direction, the external byte address, the byte offset inside the component buffer, and the byte count. The buffer offset is added to a fixed base address at which the buffer appears in the system map. Transfers move whole 128-bit words only, so the block rejects any request that is misaligned or empty. A rejected request produces an error pulse and no bus traffic. Waiting for the lock and for the engine is driven by interrupts, never by polling.

Top module: `dma_req_seq`

## Requirements
- R1: After reset, `req_ready` is 1; `av_read`, `av_write`, `done_pulse` and `err_pulse` are 0.
- R2: A request sampled while `req_ready` is 1 is rejected in three cases: `req_ext_addr` bits [3:0] are nonzero, `req_len` bits [3:0] are nonzero, or `req_len` is 0. A rejected request raises `err_pulse` for exactly one cycle, in the cycle after it is sampled. It starts no bus access, and `req_ready` stays 1.
- R3: For an accepted request, the first bus access is a read of the lock register (control address 8).
- R4: If the lock read returns bit 0 = 0, the lock is denied. The block then makes no bus access until `lock_irq` is seen high, and after that it reads the lock register again. A value of 1 in bit 0 grants the lock.
- R5: Once the lock is granted, the block makes four writes in this order. Address 1 receives the source, address 2 the destination, address 3 the byte count, and address 4 the go word 0x3. For `req_dir` = 0 (DRAM to buffer), the source is `req_ext_addr` and the destination is `BUF_BASE + req_buf_off`. For `req_dir` = 1, the two are swapped.
- R6: While `av_waitreq` is 1 during an access, `av_addr`, `av_wdata`, `av_read` and `av_write` hold their values. An access completes on a clock edge where `av_waitreq` is 0.
- R7: After the go write, the block makes no bus access until `dma_irq` is 1.
- R8: After `dma_irq`, the block writes 0 to address 0, which acknowledges the interrupt. It then writes 0 to address 8, which frees the lock. `done_pulse` is 1 for one cycle, in the cycle after the freeing write completes, and `req_ready` returns to 1.
- R9: A read and a write are never requested at the same time. While `req_ready` is 0, `req_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request strobe |
| req_dir | input | 1 | 0: DRAM to buffer, 1: buffer to DRAM |
| req_ext_addr | input | 32 | External byte address |
| req_buf_off | input | 16 | Byte offset in the component buffer |
| req_len | input | 24 | Byte count |
| req_ready | output | 1 | Block is idle and samples `req_valid` |
| done_pulse | output | 1 | Transfer finished and lock freed |
| err_pulse | output | 1 | Request rejected for alignment or length |
| av_addr | output | 4 | Control register word address |
| av_read | output | 1 | Read request |
| av_write | output | 1 | Write request |
| av_wdata | output | 32 | Write data |
| av_rdata | input | 32 | Read data, valid when `av_waitreq` is 0 |
| av_waitreq | input | 1 | Target stall |
| lock_irq | input | 1 | Lock has become free |
| dma_irq | input | 1 | DMA engine finished (level) |

## Verification
The hardest situation to reach is a lock denial that coincides with a stalled bus. A denied read must leave the block silent until the lock interrupt arrives, and the retry must keep its address stable through random wait states. The bench's slave model denies the lock a chosen number of times and fires the lock interrupt a random number of cycles later. The slave model also inserts random wait requests. A request that arrives while the block is busy, and the engine interrupt delayed by random amounts, complete the hard cases.

// File: rtl/dma_req_seq.sv
module dma_req_seq #(
  parameter int DW = 32,
  parameter int OFFW = 16,
  parameter int LENW = 24,
  parameter int CAW = 4,
  parameter int WORD_BYTES = 16,
  parameter logic [DW-1:0] BUF_BASE = 32'h8000_0000,
  parameter logic [DW-1:0] CTRL_GO = 32'h0000_0003
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_dir,
  input  logic [DW-1:0]   req_ext_addr,
  input  logic [OFFW-1:0] req_buf_off,
  input  logic [LENW-1:0] req_len,
  output logic            req_ready,
  output logic            done_pulse,
  output logic            err_pulse,
  output logic [CAW-1:0]  av_addr,
  output logic            av_read,
  output logic            av_write,
  output logic [DW-1:0]   av_wdata,
  input  logic [DW-1:0]   av_rdata,
  input  logic            av_waitreq,
  input  logic            lock_irq,
  input  logic            dma_irq
);
  localparam int AB = $clog2(WORD_BYTES);
  localparam logic [CAW-1:0] A_STAT = CAW'(0);
  localparam logic [CAW-1:0] A_SRC  = CAW'(1);
  localparam logic [CAW-1:0] A_DST  = CAW'(2);
  localparam logic [CAW-1:0] A_LEN  = CAW'(3);
  localparam logic [CAW-1:0] A_CTRL = CAW'(4);
  localparam logic [CAW-1:0] A_LOCK = CAW'(8);

  typedef enum logic [2:0] {S_IDLE, S_ACQ, S_WLOCK, S_PROG, S_WDONE, S_ACK, S_REL} st_t;

  st_t st;
  logic [1:0] idx;
  logic [DW-1:0] src_q, dst_q;
  logic [LENW-1:0] len_q;
  logic bad, granted;
  logic [DW-1:0] buf_addr;
  logic unused_rdata;

  assign unused_rdata = ^av_rdata[DW-1:1];
  assign bad = (|req_ext_addr[AB-1:0]) || (|req_len[AB-1:0]) || (req_len == '0);
  assign buf_addr = BUF_BASE + DW'(req_buf_off);
  assign granted = av_rdata[0];
  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      idx <= '0;
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
      done_pulse <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      err_pulse <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (bad) err_pulse <= 1'b1;
          else begin
            src_q <= req_dir ? buf_addr : req_ext_addr;
            dst_q <= req_dir ? req_ext_addr : buf_addr;
            len_q <= req_len;
            st <= S_ACQ;
          end
        end
        S_ACQ: if (!av_waitreq) begin
          if (granted) begin
            st <= S_PROG;
            idx <= '0;
          end else st <= S_WLOCK;
        end
        S_WLOCK: if (lock_irq) st <= S_ACQ;
        S_PROG: if (!av_waitreq) begin
          if (idx == 2'd3) st <= S_WDONE;
          idx <= idx + 2'd1;
        end
        S_WDONE: if (dma_irq) st <= S_ACK;
        S_ACK: if (!av_waitreq) st <= S_REL;
        S_REL: if (!av_waitreq) begin
          st <= S_IDLE;
          done_pulse <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    av_read = 1'b0;
    av_write = 1'b0;
    av_addr = A_LOCK;
    av_wdata = '0;
    case (st)
      S_ACQ: av_read = 1'b1;
      S_PROG: begin
        av_write = 1'b1;
        case (idx)
          2'd0: begin av_addr = A_SRC; av_wdata = src_q; end
          2'd1: begin av_addr = A_DST; av_wdata = dst_q; end
          2'd2: begin av_addr = A_LEN; av_wdata = DW'(len_q); end
          default: begin av_addr = A_CTRL; av_wdata = CTRL_GO; end
        endcase
      end
      S_ACK: begin av_write = 1'b1; av_addr = A_STAT; end
      S_REL: av_write = 1'b1;
      default: ;
    endcase
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> req_ready && !av_read && !av_write);
  p_err_nobus_r2: assert property (@(posedge clk) disable iff (!rst_n) err_pulse |-> req_ready && !av_read && !av_write);
  p_pulse_excl_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done_pulse, err_pulse}));
  p_first_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !bad) |=> (av_read && av_addr == A_LOCK));
  p_deny_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (av_read && !av_waitreq && !granted) |=> (!av_read && !av_write));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((av_read || av_write) && av_waitreq) |=> ($stable(av_addr) && $stable(av_wdata) && $stable(av_read) && $stable(av_write)));
  p_no_poll_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDONE && !dma_irq) |=> (st == S_WDONE && !av_read && !av_write));
  p_done_after_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (av_write && av_addr == A_LOCK && !av_waitreq) |=> done_pulse);
  p_rw_excl_r9: assert property (@(posedge clk) disable iff (!rst_n) !(av_read && av_write));
endmodule

// File: tb/sim_dma_req_seq.sv
module sim_dma_req_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_dir = 1'b0;
  logic [31:0] req_ext_addr = '0;
  logic [15:0] req_buf_off = '0;
  logic [23:0] req_len = '0;
  logic req_ready, done_pulse, err_pulse, av_read, av_write;
  logic [3:0] av_addr;
  logic [31:0] av_wdata;
  logic [31:0] av_rdata = 32'd1;
  logic av_waitreq = 1'b0, lock_irq = 1'b0, dma_irq = 1'b0;

  int checks = 0, fails = 0;
  int done_cnt = 0, err_cnt = 0, bad_lk = 0, bad_dm = 0, bad_st = 0;
  int deny_left = 0, lk_cnt = 0, dm_cnt = 0, lg_n = 0;
  bit lk_wait = 0, dm_wait = 0, stall_en = 0, hold_prev = 0;
  logic [3:0] lg_addr [32];
  logic [31:0] lg_data [32];
  bit lg_wr [32];
  logic [3:0] p_addr;
  logic [31:0] p_data;
  logic p_rd, p_wr;

  dma_req_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model and monitor
  initial begin
    void'($urandom(32'd1234));
    forever begin
      @(negedge clk);
      if (done_pulse) done_cnt++;
      if (err_pulse) err_cnt++;
      if (hold_prev && (p_addr !== av_addr || p_data !== av_wdata || p_rd !== av_read || p_wr !== av_write)) bad_st++;
      if (lk_wait && (av_read || av_write)) bad_lk++;
      if (dm_wait && (av_read || av_write)) bad_dm++;
      lock_irq = 1'b0;
      if (lk_cnt > 0) begin
        lk_cnt--;
        if (lk_cnt == 0) begin lock_irq = 1'b1; lk_wait = 0; end
      end
      if (dm_cnt > 0) begin
        dm_cnt--;
        if (dm_cnt == 0) begin dma_irq = 1'b1; dm_wait = 0; end
      end
      av_waitreq = stall_en && ($urandom % 3 == 0);
      av_rdata = {31'd0, deny_left == 0};
      hold_prev = (av_read || av_write) && av_waitreq;
      p_addr = av_addr; p_data = av_wdata; p_rd = av_read; p_wr = av_write;
      if ((av_read || av_write) && !av_waitreq) begin
        if (lg_n < 32) begin
          lg_addr[lg_n] = av_addr; lg_data[lg_n] = av_wdata; lg_wr[lg_n] = av_write;
          lg_n++;
        end
        if (av_read && deny_left > 0) begin
          deny_left--;
          lk_cnt = 1 + int'($urandom % 4);
          lk_wait = 1;
        end
        if (av_write && av_addr == 4'd4) begin
          dm_cnt = 1 + int'($urandom % 6);
          dm_wait = 1;
        end
        if (av_write && av_addr == 4'd0) dma_irq = 1'b0;
      end
    end
  end

  task automatic run_req(input bit dir, input logic [31:0] ext, input logic [15:0] off,
                         input logic [23:0] len, input int deny, input bit inject);
    bit expect_err;
    int n;
    logic [31:0] src, dst;
    expect_err = (ext[3:0] != 0) || (len[3:0] != 0) || (len == 0);
    @(negedge clk); #1;
    lg_n = 0; done_cnt = 0; err_cnt = 0; bad_lk = 0; bad_dm = 0; bad_st = 0;
    deny_left = deny;
    req_valid = 1'b1; req_dir = dir; req_ext_addr = ext; req_buf_off = off; req_len = len;
    @(negedge clk); #1;
    req_valid = 1'b0;
    if (expect_err) begin
      chk(err_cnt == 1, "R2 err pulse", err_cnt, 1);
      repeat (4) @(negedge clk);
      #1;
      chk(lg_n == 0 && done_cnt == 0 && err_cnt == 1 && req_ready, "R2 no bus", lg_n, 0);
      return;
    end
    n = 0;
    while (done_cnt == 0 && n < 3000) begin
      if (inject && n == 3) begin
        chk(req_ready == 1'b0, "R9 busy ready", req_ready, 0);
        req_valid = 1'b1; req_ext_addr = 32'h40; req_len = 24'h20; req_dir = ~dir;
      end
      if (inject && n == 8) req_valid = 1'b0;
      @(negedge clk); #1;
      n++;
    end
    req_valid = 1'b0;
    chk(done_cnt == 1, "R8 done", done_cnt, 1);
    repeat (3) @(negedge clk);
    #1;
    chk(done_cnt == 1 && err_cnt == 0 && req_ready, "R8 single done", done_cnt, 1);
    chk(lg_n == deny + 7, "R5 access count", lg_n, deny + 7);
    chk(bad_lk == 0, "R4 quiet while denied", bad_lk, 0);
    chk(bad_dm == 0, "R7 no poll", bad_dm, 0);
    chk(bad_st == 0, "R6 hold under stall", bad_st, 0);
    if (lg_n != deny + 7) return;
    for (int i = 0; i <= deny; i++)
      chk(!lg_wr[i] && lg_addr[i] == 4'd8, i == 0 ? "R3 lock read" : "R4 lock retry", lg_addr[i], 8);
    src = dir ? BASE + 32'(off) : ext;
    dst = dir ? ext : BASE + 32'(off);
    chk(lg_wr[deny+1] && lg_addr[deny+1] == 4'd1 && lg_data[deny+1] == src, "R5 src", lg_data[deny+1], src);
    chk(lg_wr[deny+2] && lg_addr[deny+2] == 4'd2 && lg_data[deny+2] == dst, "R5 dst", lg_data[deny+2], dst);
    chk(lg_wr[deny+3] && lg_addr[deny+3] == 4'd3 && lg_data[deny+3] == 32'(len), "R5 len", lg_data[deny+3], len);
    chk(lg_wr[deny+4] && lg_addr[deny+4] == 4'd4 && lg_data[deny+4] == 32'h3, "R5 go", lg_data[deny+4], 3);
    chk(lg_wr[deny+5] && lg_addr[deny+5] == 4'd0 && lg_data[deny+5] == 0, "R8 irq ack", lg_addr[deny+5], 0);
    chk(lg_wr[deny+6] && lg_addr[deny+6] == 4'd8 && lg_data[deny+6] == 0, "R8 lock free", lg_addr[deny+6], 8);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1;
    chk(req_ready && !av_read && !av_write && !done_pulse && !err_pulse, "R1 reset state",
        {req_ready, av_read, av_write, done_pulse, err_pulse}, 5'b10000);
    rst_n = 1'b1;
    run_req(1'b0, 32'h0000_1000, 16'h0040, 24'h000100, 0, 0);
    stall_en = 1;
    run_req(1'b1, 32'h1234_5670, 16'h0010, 24'h000030, 2, 0);
    run_req(1'b0, 32'h0000_1008, 16'h0, 24'h000010, 0, 0);
    run_req(1'b0, 32'h0000_1000, 16'h0, 24'h000018, 0, 0);
    run_req(1'b1, 32'h0000_2000, 16'h0, 24'h000000, 0, 0);
    run_req(1'b1, 32'hFFFF_FFF0, 16'hFFF0, 24'hFFFFF0, 1, 0);
    run_req(1'b0, 32'h0000_3000, 16'h0100, 24'h000040, 1, 1);
    for (int k = 0; k < 30; k++) begin
      logic [31:0] a;
      logic [23:0] l;
      a = $urandom;
      l = 24'($urandom);
      if ($urandom % 4 != 0) begin a[3:0] = 0; l[3:0] = 0; end
      run_req(1'($urandom), a, 16'($urandom), l, int'($urandom % 3), 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule